// File: doc/BRIEF.md
# TDM Codec Serial Link Controller

This block is the controller end of a time-division-multiplexed serial link to an audio codec. The codec supplies the bit clock, and the controller runs entirely on it. Each frame lasts 256 bit clocks. The controller marks the start of every frame with a frame sync pulse. During the frame it shifts one outbound frame of slot words onto its serial output and collects the inbound frame from its serial input. On the parallel side it takes per-slot transmit words with per-slot valid flags, and it returns the received slot words once per frame together with a frame-done strobe.

After reset the link uses the mixed layout: a 16-bit tag slot followed by twelve 20-bit slots. The controller sends only zeros until the codec reports ready through the first bit of its inbound tag. It then sends exactly one register-write frame in the mixed layout. That write sets the codec's uniform-slot enable. From the frame after the write onward, both sides use sixteen equal 16-bit slots. The controller keeps that layout until the next reset.

Top module: `tdm_link_ctrl`

## Requirements
- R1: While `rst_n` is low, `frame_sync`, `ser_out`, `codec_ready`, `uniform_mode` and `frame_done` are all 0 and `rx_slot_data` is all zeros.
- R2: The first frame begins at the first rising edge of `bit_clk` after reset is released. Frames follow one another with no gap, each 256 bit clocks long, and `frame_sync` is high for exactly the first 16 bit clocks of each frame.
- R3: `ser_out` changes only after a rising edge of `bit_clk`, and `ser_in` is sampled on the falling edge. Each slot word is sent and received most significant bit first.
- R4: `codec_ready` equals the first inbound bit of the most recent frame, which is bit 15 of the inbound tag. It is updated on the falling edge of that bit.
- R5: Until a frame has arrived with the ready bit high, every outbound bit is 0, whatever is on `tx_slot_valid` and `tx_slot_data`. The frame in which ready is first seen is also all zeros.
- R6: The frame that follows the first frame with ready high is a register write in the mixed layout. Its tag is 0xE000. Slot 1 carries the 16-bit word {0 (write), CFG_ADDR (7 bits, default 0x74), 8'h00}. Slot 2 carries CFG_DATA (default 0x0800). Each 20-bit slot holds its word left-aligned and ends with four 0 bits. Slots 3 to 12 are 0.
- R7: `uniform_mode` rises together with the `frame_done` pulse that closes the register-write frame and stays high until reset. Every later frame carries slot k in bits 16k to 16k+15 counted from the frame start.
- R8: In uniform frames, tag bit 15 is the OR of all `tx_slot_valid` bits, tag bit 15-k is `tx_slot_valid[k-1]`, and tag bits 2:0 are 0. A slot whose valid flag is clear is sent as zeros. Slots 13 to 15 are always zero. The transmit inputs are sampled at the rising edge that starts the frame.
- R9: `rx_slot_data[16k+15:16k]` holds inbound slot k (k = 0..12) of the previous frame. In the mixed layout only the upper 16 bits of each 20-bit slot are kept. Inbound slots 13 to 15 are ignored. The output updates at the same edge where `frame_done` rises.
- R10: `frame_done` is high for one bit clock at the start of every frame except the first frame after reset, aligned with the rising frame sync.
- R11: Asserting reset in the middle of a frame returns the controller to the mixed layout and to waiting for ready. The frame after release sends zeros again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Inbound serial data from the codec |
| tx_slot_valid | input | 12 | Valid flag per outbound slot, bit k-1 for slot k |
| tx_slot_data | input | 192 | Outbound slot words, slot k at bits 16(k-1)+15:16(k-1) |
| frame_sync | output | 1 | Frame sync, high during the tag slot |
| ser_out | output | 1 | Outbound serial data to the codec |
| rx_slot_data | output | 208 | Received slot words of the last frame, slot k at bits 16k+15:16k |
| codec_ready | output | 1 | Codec-ready flag from the inbound tag |
| uniform_mode | output | 1 | High once the link uses sixteen 16-bit slots |
| frame_done | output | 1 | One-cycle strobe at each frame boundary |

## Verification
Some properties are checked by assertions on every cycle. These include the quiet serial output while the controller waits for ready, the frame sync rising at each frame-done strobe, the mode flag changing only at a frame boundary and never falling back, the slot counter closing its last slot exactly on the final bit of the frame, and the ready flag staying stable outside the tag slot. Other behaviour is shown only by the bench's scenarios, which play the codec bit by bit. Those scenarios cover the exact bit layout of the register-write frame with its four-bit padding, the tag and slot contents built from the valid mask, the dropping of receive padding and of the unused high slots, and the return to the zero-filled mixed layout after a reset in mid-frame.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

   // Link sequencing: quiet until ready, one mixed-layout write, then uniform slots
   typedef enum logic [1:0] {
      LNK_WAIT_RDY = 2'd0,
      LNK_CFG_WR   = 2'd1,
      LNK_UNIFORM  = 2'd2
   } link_state_e;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
   parameter int WORD_W     = 16,
   parameter int WIDE_W     = 20,
   parameter int N_SLOTS    = 13,
   parameter int FRAME_BITS = 256,
   parameter int CNT_W      = 8,
   parameter int SLOT_IDX_W = 4,
   parameter int POS_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wide,
   output logic                  started,
   output logic [CNT_W-1:0]      bit_cnt,
   output logic [SLOT_IDX_W-1:0] slot,
   output logic [POS_W-1:0]      pos,
   output logic                  frame_end,
   output logic                  frame_sync
);

   localparam int UNI_LAST = FRAME_BITS / WORD_W - 1;

   logic [POS_W-1:0] pos_last;
   logic             last_pos;

   always_comb begin
      if (wide && slot != '0) pos_last = POS_W'(WIDE_W - 1);
      else                    pos_last = POS_W'(WORD_W - 1);
   end

   assign last_pos   = (pos == pos_last);
   assign frame_end  = started && (bit_cnt == CNT_W'(FRAME_BITS - 1));
   assign frame_sync = started && (bit_cnt < CNT_W'(WORD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         bit_cnt <= '0;
         slot    <= '0;
         pos     <= '0;
      end else if (!started) begin
         started <= 1'b1;
      end else if (frame_end) begin
         bit_cnt <= '0;
         slot    <= '0;
         pos     <= '0;
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
         if (last_pos) begin
            pos  <= '0;
            slot <= slot + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   AST_FRAME_CLOSES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> (last_pos && (slot == (wide ? SLOT_IDX_W'(N_SLOTS - 1) : SLOT_IDX_W'(UNI_LAST)))))
      else $error("frame ended inside a slot"); // R2

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
   parameter int WORD_W     = 16,
   parameter int N_SLOTS    = 13,
   parameter int SLOT_IDX_W = 4,
   parameter int POS_W      = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [N_SLOTS*WORD_W-1:0]   load_words,
   input  logic                        active,
   input  logic [SLOT_IDX_W-1:0]       slot,
   input  logic [POS_W-1:0]            pos,
   output logic                        ser_out
);

   localparam int BIT_W = $clog2(WORD_W);

   logic [WORD_W-1:0]  words_q [N_SLOTS];
   logic               in_word;
   logic [BIT_W-1:0]   bit_sel;
   logic [N_SLOTS-1:0] hit_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_SLOTS; k++) words_q[k] <= '0;
      end else if (load) begin
         for (int k = 0; k < N_SLOTS; k++) words_q[k] <= load_words[k*WORD_W +: WORD_W];
      end
   end

   // Positions past the word width are the zero padding of a wide slot
   assign in_word = (pos < POS_W'(WORD_W));
   assign bit_sel = BIT_W'(WORD_W - 1) - pos[BIT_W-1:0];

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot_mux
      assign hit_bits[k] = (slot == SLOT_IDX_W'(k)) && in_word && words_q[k][bit_sel];
   end

   assign ser_out = active && (|hit_bits);

endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer #(
   parameter int WORD_W     = 16,
   parameter int N_SLOTS    = 13,
   parameter int SLOT_IDX_W = 4,
   parameter int POS_W      = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      active,
   input  logic                      ser_in,
   input  logic [SLOT_IDX_W-1:0]     slot,
   input  logic [POS_W-1:0]          pos,
   output logic                      ready_bit,
   output logic [N_SLOTS*WORD_W-1:0] words_o
);

   logic [WORD_W-2:0] shift_q;
   logic [WORD_W-1:0] cap_q [N_SLOTS];
   logic              in_word;
   logic              last_bit;

   assign in_word  = (pos < POS_W'(WORD_W));
   assign last_bit = (pos == POS_W'(WORD_W - 1));

   // Inbound bits are taken on the falling edge, half a bit after the codec drives them
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q   <= '0;
         ready_bit <= 1'b0;
         for (int k = 0; k < N_SLOTS; k++) cap_q[k] <= '0;
      end else if (active && in_word) begin
         shift_q <= {shift_q[WORD_W-3:0], ser_in};
         if (slot == '0 && pos == '0) ready_bit <= ser_in;
         for (int k = 0; k < N_SLOTS; k++) begin
            if (last_bit && slot == SLOT_IDX_W'(k)) cap_q[k] <= {shift_q, ser_in};
         end
      end
   end

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_rx_out
      assign words_o[k*WORD_W +: WORD_W] = cap_q[k];
   end

   AST_READY_ONLY_IN_TAG: assert property (@(negedge clk) disable iff (!rst_n)
      (slot != '0) |-> $stable(ready_bit))
      else $error("ready flag moved outside the tag slot"); // R4

endmodule

// File: rtl/tdm_link_ctrl.sv
module tdm_link_ctrl
   import tdm_link_pkg::*;
#(
   parameter int              WORD_W   = 16,
   parameter int              WIDE_W   = 20,
   parameter int              N_SLOTS  = 13,
   parameter int              ADDR_W   = 7,
   parameter logic [6:0]      CFG_ADDR = 7'h74,
   parameter logic [15:0]     CFG_DATA = 16'h0800
) (
   input  logic                          bit_clk,
   input  logic                          rst_n,
   input  logic                          ser_in,
   input  logic [N_SLOTS-2:0]            tx_slot_valid,
   input  logic [(N_SLOTS-1)*WORD_W-1:0] tx_slot_data,
   output logic                          frame_sync,
   output logic                          ser_out,
   output logic [N_SLOTS*WORD_W-1:0]     rx_slot_data,
   output logic                          codec_ready,
   output logic                          uniform_mode,
   output logic                          frame_done
);

   localparam int FRAME_BITS = WORD_W + (N_SLOTS - 1) * WIDE_W;
   localparam int UNI_SLOTS  = FRAME_BITS / WORD_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);
   localparam int SLOT_IDX_W = $clog2(UNI_SLOTS);
   localparam int POS_W      = $clog2(WIDE_W);
   localparam logic [WORD_W-1:0] TAG_CFG = WORD_W'(7) << (WORD_W - 3);

   // Parameter sanity, caught at elaboration
   if (WIDE_W <= WORD_W) begin : g_bad_wide
      $error("wide slot must be longer than the word");
   end
   if (FRAME_BITS % WORD_W != 0) begin : g_bad_frame
      $error("frame length must split into whole narrow slots");
   end
   if (UNI_SLOTS < N_SLOTS) begin : g_bad_slots
      $error("uniform layout must hold every slot");
   end
   if (N_SLOTS - 1 > WORD_W - 1) begin : g_bad_tag
      $error("tag word too narrow for the slot valid flags");
   end
   if (ADDR_W + 1 > WORD_W || ADDR_W != $bits(CFG_ADDR)) begin : g_bad_addr
      $error("command address does not fit the slot word");
   end
   if ($bits(CFG_DATA) != WORD_W) begin : g_bad_data
      $error("command data width must equal the slot word");
   end

   link_state_e                 st_q, st_nxt;
   logic                        started, frame_end, wide;
   logic [CNT_W-1:0]            bit_cnt;
   logic [SLOT_IDX_W-1:0]       slot;
   logic [POS_W-1:0]            pos;
   logic [N_SLOTS*WORD_W-1:0]   next_words;
   logic [N_SLOTS*WORD_W-1:0]   rx_words;
   logic [WORD_W-1:0]           tag;

   assign wide         = (st_q != LNK_UNIFORM);
   assign uniform_mode = (st_q == LNK_UNIFORM);

   tdm_frame_timer #(
      .WORD_W(WORD_W), .WIDE_W(WIDE_W), .N_SLOTS(N_SLOTS), .FRAME_BITS(FRAME_BITS),
      .CNT_W(CNT_W), .SLOT_IDX_W(SLOT_IDX_W), .POS_W(POS_W)
   ) u_timer (
      .clk(bit_clk), .rst_n(rst_n), .wide(wide), .started(started), .bit_cnt(bit_cnt),
      .slot(slot), .pos(pos), .frame_end(frame_end), .frame_sync(frame_sync)
   );

   tdm_tx_serializer #(
      .WORD_W(WORD_W), .N_SLOTS(N_SLOTS), .SLOT_IDX_W(SLOT_IDX_W), .POS_W(POS_W)
   ) u_tx (
      .clk(bit_clk), .rst_n(rst_n), .load(frame_end), .load_words(next_words),
      .active(started), .slot(slot), .pos(pos), .ser_out(ser_out)
   );

   tdm_rx_deserializer #(
      .WORD_W(WORD_W), .N_SLOTS(N_SLOTS), .SLOT_IDX_W(SLOT_IDX_W), .POS_W(POS_W)
   ) u_rx (
      .clk(bit_clk), .rst_n(rst_n), .active(started), .ser_in(ser_in),
      .slot(slot), .pos(pos), .ready_bit(codec_ready), .words_o(rx_words)
   );

   always_comb begin
      unique case (st_q)
         LNK_WAIT_RDY: st_nxt = codec_ready ? LNK_CFG_WR : LNK_WAIT_RDY;
         LNK_CFG_WR:   st_nxt = LNK_UNIFORM;
         default:      st_nxt = LNK_UNIFORM;
      endcase
   end

   // Contents of the frame about to start, chosen by the state it will run in
   always_comb begin
      next_words = '0;
      tag        = '0;
      unique case (st_nxt)
         LNK_CFG_WR: begin
            next_words[0 +: WORD_W]        = TAG_CFG;
            next_words[WORD_W +: WORD_W]   = {1'b0, CFG_ADDR, {(WORD_W-1-ADDR_W){1'b0}}};
            next_words[2*WORD_W +: WORD_W] = CFG_DATA;
         end
         LNK_UNIFORM: begin
            tag[WORD_W-1] = |tx_slot_valid;
            for (int k = 1; k < N_SLOTS; k++) begin
               tag[WORD_W-1-k] = tx_slot_valid[k-1];
               if (tx_slot_valid[k-1])
                  next_words[k*WORD_W +: WORD_W] = tx_slot_data[(k-1)*WORD_W +: WORD_W];
            end
            next_words[0 +: WORD_W] = tag;
         end
         default: ;
      endcase
   end

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= LNK_WAIT_RDY;
         frame_done   <= 1'b0;
         rx_slot_data <= '0;
      end else begin
         frame_done <= frame_end;
         if (frame_end) begin
            st_q         <= st_nxt;
            rx_slot_data <= rx_words;
         end
      end
   end

   AST_QUIET_BEFORE_READY: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (st_q == LNK_WAIT_RDY) |-> !ser_out)
      else $error("traffic sent before codec ready"); // R5

   AST_MODE_STICKY: assert property (@(posedge bit_clk) disable iff (!rst_n)
      uniform_mode |=> uniform_mode)
      else $error("uniform mode dropped"); // R7

   AST_MODE_AT_BOUNDARY: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $rose(uniform_mode) |-> frame_done)
      else $error("layout switched inside a frame"); // R7

   AST_DONE_WITH_SYNC: assert property (@(posedge bit_clk) disable iff (!rst_n)
      frame_done |-> $rose(frame_sync))
      else $error("frame strobe not aligned with sync"); // R10

endmodule

// File: tb/tb_tdm_link_ctrl.sv
module tb_tdm_link_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int NS = 13;
   localparam logic [6:0]  EXP_ADDR = 7'h74;
   localparam logic [15:0] EXP_DATA = 16'h0800;

   typedef logic [W-1:0] word_t;
   typedef word_t frame_t [NS];

   logic                   bit_clk = 1'b0;
   logic                   rst_n;
   logic                   ser_in;
   logic [NS-2:0]          tx_slot_valid;
   logic [(NS-1)*W-1:0]    tx_slot_data;
   logic                   frame_sync, ser_out, codec_ready, uniform_mode, frame_done;
   logic [NS*W-1:0]        rx_slot_data;

   int                     n_chk = 0;
   int                     n_bad = 0;
   logic                   first;
   logic [NS*W-1:0]        prev_rx;

   tdm_link_ctrl dut (
      .bit_clk(bit_clk), .rst_n(rst_n), .ser_in(ser_in),
      .tx_slot_valid(tx_slot_valid), .tx_slot_data(tx_slot_data),
      .frame_sync(frame_sync), .ser_out(ser_out), .rx_slot_data(rx_slot_data),
      .codec_ready(codec_ready), .uniform_mode(uniform_mode), .frame_done(frame_done)
   );

   always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

   task automatic chk(input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [255:0] pack(input frame_t w, input logic uni,
                                         input logic [3:0] pad, input word_t fill);
      logic [255:0] f;
      int p;
      f = '0;
      f[255 -: 16] = w[0];
      p = 239;
      for (int k = 1; k < NS; k++) begin
         if (uni) begin f[p -: 16] = w[k]; p -= 16; end
         else     begin f[p -: 20] = {w[k], pad}; p -= 20; end
      end
      if (uni) while (p >= 0) begin f[p -: 16] = fill; p -= 16; end
      return f;
   endfunction

   function automatic logic [NS*W-1:0] flat(input frame_t w);
      logic [NS*W-1:0] v;
      for (int k = 0; k < NS; k++) v[k*W +: W] = w[k];
      return v;
   endfunction

   function automatic frame_t mk_in(input word_t tag, input word_t seed);
      frame_t w;
      w[0] = tag;
      for (int k = 1; k < NS; k++) w[k] = seed ^ word_t'(k * 16'h1357);
      return w;
   endfunction

   function automatic logic [255:0] exp_cfg();
      frame_t w;
      for (int k = 0; k < NS; k++) w[k] = '0;
      w[0] = 16'hE000;
      w[1] = {1'b0, EXP_ADDR, 8'h00};
      w[2] = EXP_DATA;
      return pack(w, 1'b0, 4'h0, 16'h0);
   endfunction

   function automatic logic [255:0] exp_norm(input logic [NS-2:0] v, input logic [(NS-1)*W-1:0] d);
      frame_t w;
      w[0] = '0;
      w[0][15] = |v;
      for (int k = 1; k < NS; k++) begin
         w[0][15-k] = v[k-1];
         w[k] = v[k-1] ? d[(k-1)*W +: W] : '0;
      end
      return pack(w, 1'b1, 4'h0, 16'h0);
   endfunction

   // Plays the codec for one whole frame and checks both directions
   task automatic run_frame(input frame_t iw, input logic uni,
                            input logic [255:0] exp_out, input string req_out);
      logic [255:0] ibits, obits;
      int sync_bad;
      ibits = pack(iw, uni, 4'hA, 16'hFFFF);
      obits = '0;
      sync_bad = 0;
      for (int i = 0; i < 256; i++) begin
         @(posedge bit_clk); #1;
         ser_in = ibits[255-i];
         @(negedge bit_clk); #1;
         obits[255-i] = ser_out;
         if (frame_sync !== (i < 16)) sync_bad++;
         if (i == 0) begin
            chk("R10", "frame_done at boundary", 256'(frame_done), 256'(!first));
            chk("R7", "uniform_mode", 256'(uniform_mode), 256'(uni));
            if (!first) chk("R9", "received slots", 256'(rx_slot_data), 256'(prev_rx));
         end
         if (i == 1) begin
            chk("R10", "frame_done one cycle", 256'(frame_done), 256'(0));
            chk("R4", "codec_ready", 256'(codec_ready), 256'(iw[0][15]));
         end
      end
      chk("R2", "sync window errors", 256'(sync_bad), 256'(0));
      chk(req_out, "outbound frame", obits, exp_out);
      prev_rx = flat(iw);
      first = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      ser_in = 1'b1;
      tx_slot_valid = '1;
      for (int k = 0; k < NS-1; k++) tx_slot_data[k*W +: W] = word_t'(16'hA5C3 + k * 16'h0101);
      repeat (3) @(posedge bit_clk);
      @(negedge bit_clk); #1;
      chk("R1", "outputs in reset",
          256'({frame_sync, ser_out, codec_ready, uniform_mode, frame_done, rx_slot_data}), 256'(0));
      rst_n = 1'b1;
      first = 1'b1;
   endtask

   task automatic t_wait_ready();
      run_frame(mk_in(16'h0000, 16'h0000), 1'b0, 256'(0), "R5");
      run_frame(mk_in(16'h7FFF, 16'h5A5A), 1'b0, 256'(0), "R5");
   endtask

   task automatic t_ready_seen();
      run_frame(mk_in(16'h8000, 16'h3C3C), 1'b0, 256'(0), "R5");
   endtask

   task automatic t_config();
      run_frame(mk_in(16'h8000, 16'hF00F), 1'b0, exp_cfg(), "R6,R3");
   endtask

   task automatic t_uniform();
      logic [NS-2:0]       v;
      logic [(NS-1)*W-1:0] d;
      v = '1;
      d = tx_slot_data;
      run_frame(mk_in(16'h8000, 16'h1234), 1'b1, exp_norm(v, d), "R8,R7");
      tx_slot_valid = 12'b1010_0000_0011;
      tx_slot_data  = ~tx_slot_data;
      v = tx_slot_valid;
      d = tx_slot_data;
      run_frame(mk_in(16'h8000, 16'hBEEF), 1'b1, exp_norm(v, d), "R8");
      tx_slot_valid = '0;
      run_frame(mk_in(16'h8000, 16'h0F0F), 1'b1, 256'(0), "R8");
   endtask

   task automatic t_mid_reset();
      repeat (40) @(posedge bit_clk);
      @(negedge bit_clk); #1;
      rst_n = 1'b0;
      #1;
      chk("R11", "outputs after mid-frame reset",
          256'({frame_sync, ser_out, codec_ready, uniform_mode, frame_done}), 256'(0));
      tx_slot_valid = '1;
      repeat (2) @(posedge bit_clk);
      @(negedge bit_clk); #1;
      rst_n = 1'b1;
      first = 1'b1;
      run_frame(mk_in(16'h0000, 16'h7777), 1'b0, 256'(0), "R11");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      ser_in = 1'b0;
      rst_n = 1'b0;
      first = 1'b1;
      prev_rx = '0;
      tx_slot_valid = '0;
      tx_slot_data = '0;
      t_reset();
      t_wait_ready();
      t_ready_seen();
      t_config();
      t_uniform();
      t_mid_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule